// File: doc/BRIEF.md
# Register-Programmed SPI Shift Controller

This block is an 8-bit SPI shift engine that sits on a byte-wide register bus. Software programs a control register, starts transfers by writing the data register, and watches the status register or an interrupt line for completion. In master mode the block makes the serial clock from the system clock. One of four dividers picks its rate. The block shifts its transmit byte out on the master-out line and collects the reply from the master-in line. In slave mode it follows a serial clock supplied from outside, qualified by an active-low select. It returns its own byte on the master-in line.

Clock idle level, sampling phase and bit order are all programmable. The status register carries a completion flag and a write-collision flag. Both flags clear through a two-step sequence: a status read, then any data-register access. The interrupt request is the completion flag gated by an enable bit.

Register select codes: 0 is control, 1 is status, 2 is data. Control bits: [7] interrupt enable, [6] block enable, [5] bit order, [4] master select, [3] clock polarity, [2] clock phase, [1:0] rate. Status bits: [7] completion, [6] collision, all other bits zero.

Top module: `spi_regctl`

## Requirements
- R1: In master mode, the clock period is 4, 16, 64 or 128 system clocks for rate code 00, 01, 10 or 11 (control bits [1:0]), and each transfer has exactly 8 clock pulses.
- R2: Control bit 3 sets the serial clock idle level: 1 idles high, 0 idles low.
- R3: With control bit 2 at 0, data is sampled on the leading clock edge and changed on the trailing edge. With bit 2 at 1, data changes on the leading edge and is sampled on the trailing edge.
- R4: Control bit 5 at 0 sends and receives MSB first. At 1, it sends and receives LSB first.
- R5: Control bit 6 enables the block, and control bit 4 selects master (1) or slave (0). While the block is disabled, a data write starts nothing: the clock stays idle and no completion is flagged.
- R6: Status bit 7 sets once 8 bits have been exchanged. After that, the received byte reads back from the data register (select 2).
- R7: A data write during an active transfer sets status bit 6. That write is discarded, and the transfer in progress still sends and receives its original bytes.
- R8: A status read followed by a data-register access clears status bits 7 and 6. A data access with no status read before it leaves them set.
- R9: The interrupt request equals status bit 7 ANDed with control bit 7.
- R10: After reset, control and status read zero, the clock output is low and the interrupt request is low.
- R11: In slave mode, the block shifts on the external clock only while the select is low. Clock edges seen while the select is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 2 | Register select: 0 control, 1 status, 2 data |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (side effects only) |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request |
| sckO | output | 1 | Serial clock driven in master mode |
| sckI | input | 1 | Serial clock received in slave mode |
| ssN | input | 1 | Active-low slave select |
| mosiO | output | 1 | Master-out data, driven in master mode |
| mosiI | input | 1 | Master-out data received in slave mode |
| misoO | output | 1 | Master-in data, driven in slave mode |
| misoI | input | 1 | Master-in data received in master mode |

## Verification
On every cycle, the assertions check four things. The master clock rests at its idle level whenever no transfer runs. A finished master frame always spans sixteen clock edges. Completion rises only on a finish strobe. Both flags fall only on the two-step clearing sequence. The datapath checks that a load never coincides with a capture. Only the bench scenarios can show the values actually exchanged under each polarity, phase, order and rate. They also show that a collided write leaves both bytes intact, and that slave edges are ignored while the select is high. The bench does this by modelling the far end of the link.

// File: rtl/spi_regctl_pkg.sv
package spi_regctl_pkg;

  // Control register layout, bit 7 down to bit 0
  typedef struct packed {
    logic       intEn;
    logic       enable;
    logic       lsbFirst;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic launch;
    logic capture;
    logic finish;
    logic rxBit;
  } strobe_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

endpackage

// File: rtl/spi_regctl_ctrl.sv
module spi_regctl_ctrl import spi_regctl_pkg::*; #(
  parameter int BITS     = 8,
  parameter int BASE_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regSel,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [7:0] regWdata,
  input  logic       sckI,
  input  logic       ssN,
  input  logic       mosiI,
  input  logic       misoI,
  output ctrl_t      cfg,
  output logic       doneFlag,
  output logic       colFlag,
  output logic       sckO,
  output strobe_t    stb
);

  localparam int CNT_W    = $clog2(BASE_DIV * 16);
  localparam int EDGE_W   = $clog2(2 * BITS);
  localparam int CAP_W    = $clog2(BITS + 1);
  localparam logic [EDGE_W-1:0] EDGE_MAX = EDGE_W'(2 * BITS - 1);
  localparam logic [CNT_W-1:0]  HALF0 = CNT_W'(BASE_DIV / 2 - 1);
  localparam logic [CNT_W-1:0]  HALF1 = CNT_W'(BASE_DIV * 2 - 1);
  localparam logic [CNT_W-1:0]  HALF2 = CNT_W'(BASE_DIV * 8 - 1);
  localparam logic [CNT_W-1:0]  HALF3 = CNT_W'(BASE_DIV * 16 - 1);

  ctrl_t ctrlQ;
  logic  doneQ, colQ, armedQ;

  logic wrCtrl, wrData, rdStat, dataAcc;
  assign wrCtrl  = regWr && (regSel == SEL_CTRL);
  assign wrData  = regWr && (regSel == SEL_DATA);
  assign rdStat  = regRd && (regSel == SEL_STAT);
  assign dataAcc = (regWr || regRd) && (regSel == SEL_DATA);

  logic masterOn, slaveOn;
  assign masterOn = ctrlQ.enable && ctrlQ.master;
  assign slaveOn  = ctrlQ.enable && !ctrlQ.master;

  // ---------------- master clock generator ----------------
  logic              busyM, sckPh;
  logic [CNT_W-1:0]  halfCnt, halfLim;
  logic [EDGE_W-1:0] edgeCnt;
  logic              tick, mLead, mLast;

  always_comb begin
    case (ctrlQ.rate)
      2'd0:    halfLim = HALF0;
      2'd1:    halfLim = HALF1;
      2'd2:    halfLim = HALF2;
      default: halfLim = HALF3;
    endcase
  end

  assign tick  = busyM && (halfCnt == halfLim);
  assign mLead = !edgeCnt[0];
  assign mLast = (edgeCnt == EDGE_MAX);

  // ---------------- slave input synchronisers ----------------
  logic [1:0] sckSync, ssSync, mosiSync;
  logic       sckPrev, ssS, sckS, sEdge, sLead, sOpen;
  logic [CAP_W-1:0] capCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync  <= '0;
      ssSync   <= '1;
      mosiSync <= '0;
      sckPrev  <= 1'b0;
    end else begin
      sckSync  <= {sckSync[0], sckI};
      ssSync   <= {ssSync[0], ssN};
      mosiSync <= {mosiSync[0], mosiI};
      sckPrev  <= sckSync[1];
    end
  end

  assign ssS   = ssSync[1];
  assign sckS  = sckSync[1];
  assign sEdge = slaveOn && !ssS && (sckS != sckPrev);
  assign sLead = (sckS != ctrlQ.cpol);
  assign sOpen = (capCnt < CAP_W'(BITS));

  logic busy, load, collide;
  assign busy    = (masterOn && busyM) || (slaveOn && !ssS);
  assign load    = wrData && ctrlQ.enable && !busy;
  assign collide = wrData && ctrlQ.enable && busy;

  logic mCap, mLaunch, sCap, sLaunch, finish;
  assign mCap    = masterOn && tick && (ctrlQ.cpha ? !mLead : mLead);
  assign mLaunch = masterOn && tick && (ctrlQ.cpha ? mLead : (!mLead && !mLast));
  assign sCap    = sEdge && sOpen && (ctrlQ.cpha ? !sLead : sLead);
  assign sLaunch = sEdge && sOpen && (ctrlQ.cpha ? sLead : !sLead);
  assign finish  = (masterOn && tick && mLast) ||
                   (sCap && (capCnt == CAP_W'(BITS - 1)));

  always_comb begin
    stb.load    = load;
    stb.launch  = (load && !ctrlQ.cpha) || mLaunch || sLaunch;
    stb.capture = masterOn ? mCap : sCap;
    stb.finish  = finish;
    stb.rxBit   = masterOn ? misoI : mosiSync[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyM   <= 1'b0;
      sckPh   <= 1'b0;
      halfCnt <= '0;
      edgeCnt <= '0;
    end else if (!masterOn) begin
      busyM   <= 1'b0;
      sckPh   <= 1'b0;
      halfCnt <= '0;
      edgeCnt <= '0;
    end else if (load) begin
      busyM   <= 1'b1;
      halfCnt <= '0;
      edgeCnt <= '0;
    end else if (tick) begin
      halfCnt <= '0;
      sckPh   <= !sckPh;
      edgeCnt <= edgeCnt + 1'b1;
      if (mLast) busyM <= 1'b0;
    end else if (busyM) begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                capCnt <= '0;
    else if (!slaveOn || ssS) capCnt <= '0;
    else if (sCap)            capCnt <= capCnt + 1'b1;
  end

  // ---------------- registers and flags ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      doneQ  <= 1'b0;
      colQ   <= 1'b0;
      armedQ <= 1'b0;
    end else begin
      if (wrCtrl) ctrlQ <= ctrl_t'(regWdata);
      if (dataAcc) begin
        armedQ <= 1'b0;
        if (armedQ) begin
          doneQ <= 1'b0;
          colQ  <= 1'b0;
        end
      end
      if (rdStat)  armedQ <= 1'b1;
      if (finish)  doneQ  <= 1'b1;
      if (collide) colQ   <= 1'b1;
    end
  end

  assign cfg      = ctrlQ;
  assign doneFlag = doneQ;
  assign colFlag  = colQ;
  assign sckO     = (masterOn && sckPh) ^ ctrlQ.cpol;

  // ---------------- assertions ----------------
  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busyM |-> (sckO == ctrlQ.cpol));

  p_full_frame_r1: assert property (@(posedge clk) disable iff (!rstN)
    (masterOn && $fell(busyM)) |-> ($past(edgeCnt) == EDGE_MAX));

  p_done_on_finish_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> $past(stb.finish));

  p_col_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(colQ) |-> $past(dataAcc && armedQ));

  p_done_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doneQ) |-> $past(dataAcc && armedQ));

endmodule

// File: rtl/spi_regctl_dp.sv
module spi_regctl_dp import spi_regctl_pkg::*; #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lsbFirst,
  input  strobe_t         stb,
  input  logic [BITS-1:0] wdata,
  output logic            outBit,
  output logic [BITS-1:0] rxData
);

  logic [BITS-1:0] txSr, rxSr, rxNext;

  function automatic logic headOf(input logic [BITS-1:0] v, input logic lsb);
    return lsb ? v[0] : v[BITS-1];
  endfunction

  function automatic logic [BITS-1:0] advance(input logic [BITS-1:0] v, input logic lsb);
    return lsb ? (v >> 1) : (v << 1);
  endfunction

  assign rxNext = lsbFirst ? {stb.rxBit, rxSr[BITS-1:1]}
                           : {rxSr[BITS-2:0], stb.rxBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSr   <= '0;
      rxSr   <= '0;
      rxData <= '0;
      outBit <= 1'b0;
    end else begin
      if (stb.load) begin
        txSr <= stb.launch ? advance(wdata, lsbFirst) : wdata;
        if (stb.launch) outBit <= headOf(wdata, lsbFirst);
      end else if (stb.launch) begin
        outBit <= headOf(txSr, lsbFirst);
        txSr   <= advance(txSr, lsbFirst);
      end
      if (stb.capture) rxSr <= rxNext;
      if (stb.finish)  rxData <= stb.capture ? rxNext : rxSr;
    end
  end

  p_load_not_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> !stb.capture);

endmodule

// File: rtl/spi_regctl.sv
module spi_regctl import spi_regctl_pkg::*; #(
  parameter int BITS     = 8,
  parameter int BASE_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regSel,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       irq,
  output logic       sckO,
  input  logic       sckI,
  input  logic       ssN,
  output logic       mosiO,
  input  logic       mosiI,
  output logic       misoO,
  input  logic       misoI
);

  ctrl_t           cfg;
  strobe_t         stb;
  logic            doneFlag, colFlag, outBit;
  logic [BITS-1:0] rxData;

  spi_regctl_ctrl #(.BITS(BITS), .BASE_DIV(BASE_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .sckI(sckI), .ssN(ssN), .mosiI(mosiI), .misoI(misoI),
    .cfg(cfg), .doneFlag(doneFlag), .colFlag(colFlag), .sckO(sckO), .stb(stb)
  );

  spi_regctl_dp #(.BITS(BITS)) uDp (
    .clk(clk), .rstN(rstN), .lsbFirst(cfg.lsbFirst), .stb(stb),
    .wdata(regWdata[BITS-1:0]), .outBit(outBit), .rxData(rxData)
  );

  always_comb begin
    case (regSel)
      SEL_CTRL: regRdata = cfg;
      SEL_STAT: regRdata = {doneFlag, colFlag, 6'b0};
      SEL_DATA: regRdata = 8'(rxData);
      default:  regRdata = 8'h00;
    endcase
  end

  assign irq   = doneFlag && cfg.intEn;
  assign mosiO = (cfg.enable && cfg.master) ? outBit : 1'b0;
  assign misoO = (cfg.enable && !cfg.master) ? outBit : 1'b0;

endmodule

// File: tb/spi_regctl_test.sv
module spi_regctl_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic       regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       irq, sckO, mosiO, misoO;
  logic       sckI = 1'b0, ssN = 1'b1, mosiI = 1'b0, misoI = 1'b0;

  spi_regctl uut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq), .sckO(sckO),
    .sckI(sckI), .ssN(ssN), .mosiO(mosiO), .mosiI(mosiI), .misoO(misoO),
    .misoI(misoI)
  );

  always #2 clk = ~clk;

  int nRun = 0, nFail = 0;
  bit finished = 1'b0;
  logic [7:0] expQ[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic bitOf(input logic [7:0] b, input int i, input logic lsb);
    return lsb ? b[i] : b[7-i];
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    regSel = sel; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    regSel = sel; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    regSel = sel;
    #1 d = regRdata;
  endtask

  // far-end slave model used while the block is master
  bit         mdlOn = 1'b0;
  logic       mCpol, mCpha, mLsb, mdlPrev;
  logic [7:0] mByte, mGot;
  int         mIdx, mCnt;

  always @(negedge clk) begin
    if (mdlOn && sckO !== mdlPrev) begin
      if (mCpha ? (sckO != mCpol) : (sckO == mCpol)) begin
        if (mIdx < 8) begin
          misoI = bitOf(mByte, mIdx, mLsb);
          mIdx++;
        end
      end else begin
        if (mCnt < 8) begin
          if (mLsb) mGot[mCnt] = mosiO; else mGot[7-mCnt] = mosiO;
          mCnt++;
        end
      end
    end
    mdlPrev = sckO;
  end

  // score the completed transfer against the queue
  task automatic scoreRx(input string req, input logic [7:0] got);
    logic [7:0] e;
    e = expQ.pop_front();
    check(req, got, e);
  endtask

  task automatic masterXfer(input logic [7:0] ctl, input logic [7:0] tx,
                            input logic [7:0] sl, input int collideAt,
                            input bit plainRead, input int expHi, input string tag);
    logic [7:0] d;
    int hi, iter;
    wr(2'd0, ctl);
    mCpol = ctl[3]; mCpha = ctl[2]; mLsb = ctl[5]; mByte = sl;
    mIdx = ctl[2] ? 0 : 1;
    misoI = ctl[2] ? 1'b0 : bitOf(sl, 0, ctl[5]);
    mCnt = 0; mGot = 8'h00;
    @(negedge clk);
    mdlPrev = sckO; mdlOn = 1'b1;
    expQ.push_back(sl);
    expQ.push_back(tx);
    wr(2'd2, tx);
    hi = 0; iter = 0;
    forever begin
      @(negedge clk);
      regWr = 1'b0; regSel = 2'd1;
      if (collideAt != 0 && iter == collideAt) begin
        regSel = 2'd2; regWdata = 8'hFF; regWr = 1'b1;
      end
      #1;
      if (!regWr && regRdata[7]) break;
      if (sckO != ctl[3]) hi++;
      iter++;
    end
    mdlOn = 1'b0;
    check({"R1 clock-active cycles ", tag}, hi, expHi);
    peek(2'd1, d);
    check({"R6/R7 status ", tag}, d, (collideAt != 0) ? 8'hC0 : 8'h80);
    if (plainRead) begin
      rd(2'd2, d);
      peek(2'd1, d);
      check({"R8 data access alone keeps flags ", tag}, d, 8'h80);
    end
    rd(2'd1, d);
    rd(2'd2, d);
    scoreRx({"R3/R4/R6 received byte ", tag}, d);
    scoreRx({"R3/R4/R7 bits seen on mosi ", tag}, mGot);
    peek(2'd1, d);
    check({"R8 flags cleared ", tag}, d, 8'h00);
  endtask

  task automatic slaveXfer(input logic [7:0] ctl, input logic [7:0] tx,
                           input logic [7:0] mb, input string tag);
    logic [7:0] d, got;
    logic cpol, cpha, lsb;
    cpol = ctl[3]; cpha = ctl[2]; lsb = ctl[5];
    sckI = cpol;
    wr(2'd0, ctl);
    wr(2'd2, tx);
    repeat (4) @(negedge clk);
    got = 8'h00;
    ssN = 1'b0;
    if (!cpha) mosiI = bitOf(mb, 0, lsb);
    repeat (4) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      repeat (8) @(negedge clk);
      if (!cpha) begin
        if (lsb) got[k] = misoO; else got[7-k] = misoO;
      end
      sckI = ~cpol;
      if (cpha) mosiI = bitOf(mb, k, lsb);
      repeat (8) @(negedge clk);
      if (cpha) begin
        if (lsb) got[k] = misoO; else got[7-k] = misoO;
      end
      sckI = cpol;
      if (!cpha && k < 7) mosiI = bitOf(mb, k + 1, lsb);
    end
    repeat (8) @(negedge clk);
    ssN = 1'b1;
    repeat (4) @(negedge clk);
    expQ.push_back(mb);
    expQ.push_back(tx);
    peek(2'd1, d);
    check({"R11/R6 slave done ", tag}, d, 8'h80);
    rd(2'd1, d);
    rd(2'd2, d);
    scoreRx({"R11/R3/R4 slave received ", tag}, d);
    scoreRx({"R11/R3/R4 slave sent on miso ", tag}, got);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    peek(2'd0, d); check("R10 control after reset", d, 8'h00);
    peek(2'd1, d); check("R10 status after reset", d, 8'h00);
    check("R10 sck after reset", sckO, 1'b0);
    check("R10 irq after reset", irq, 1'b0);

    // R5 disabled: a data write starts nothing
    wr(2'd0, 8'h10);
    wr(2'd2, 8'h55);
    begin
      int moved = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (sckO !== 1'b0) moved++;
      end
      check("R5 disabled sck stays idle", moved, 0);
    end
    peek(2'd1, d); check("R5 disabled no completion", d, 8'h00);

    // R2 idle level follows polarity
    wr(2'd0, 8'h58);
    @(negedge clk); check("R2 idle high with polarity 1", sckO, 1'b1);
    wr(2'd0, 8'h50);
    @(negedge clk); check("R2 idle low with polarity 0", sckO, 1'b0);

    // master transfers: rate, phase, polarity, order
    masterXfer(8'h50, 8'hA5, 8'h3C, 0, 1'b0, 16,  "rate0 cpha0 msb");
    masterXfer(8'h55, 8'h96, 8'h69, 0, 1'b1, 64,  "rate1 cpha1 msb");
    masterXfer(8'h7A, 8'h1E, 8'hB2, 0, 1'b0, 256, "rate2 cpol1 lsb");
    // R7 collision mid-transfer, write discarded
    masterXfer(8'h5F, 8'hC3, 8'h81, 100, 1'b0, 512, "rate3 cpol1 cpha1 collide");

    // R9 interrupt gating
    wr(2'd0, 8'hD0);
    mdlOn = 1'b0;
    wr(2'd2, 8'h0F);
    repeat (40) @(negedge clk);
    check("R9 irq with enable set", irq, 1'b1);
    wr(2'd0, 8'h50);
    @(negedge clk);
    check("R9 irq masked when enable clear", irq, 1'b0);
    peek(2'd1, d); check("R9 completion still set while masked", d, 8'h80);
    rd(2'd1, d); rd(2'd2, d);

    // R11 slave: edges ignored while select high
    wr(2'd0, 8'h40);
    for (int i = 0; i < 5; i++) begin
      repeat (6) @(negedge clk); sckI = 1'b1;
      repeat (6) @(negedge clk); sckI = 1'b0;
    end
    repeat (6) @(negedge clk);
    peek(2'd1, d); check("R11 edges with select high ignored", d, 8'h00);
    slaveXfer(8'h40, 8'h5A, 8'hC6, "cpha0 msb");
    slaveXfer(8'h6C, 8'h3B, 8'h94, "cpol1 cpha1 lsb");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule